// File: doc/BRIEF.md
# IO Bus Address Router

This block sits on a 16-bit external IO bus that the processor drives with its load-IO and store-IO instructions. Each bus cycle carries an address, write data and a write or read request. The router examines the upper address bits with prefixes of different lengths, from 2 to 10 bits, and sends the access to exactly one peripheral: an LED register, a two-register UART window, a character LCD driven at the level of its pins, a program-memory write port or a video-RAM write port.

The LED register and the LCD pin registers are held inside the router. For the LCD, each interface line has its own 16-byte address window, so software drives the register select, read/write and enable lines and the 4-bit data nibble with ordinary stores. The router produces no display timing. The UART, the program memory and the video RAM are outside the block. The router gives them same-cycle write strobes, offsets and the write data, and it registers UART read data for a response one cycle after the request.

Top module: `iobus_router`

## Requirements
- R1: A write to an address in 0x0000..0x003F loads `led_out` with `io_wdata[7:0]` at the next clock edge, and a 1 bit means the LED is lit. Data bits 15..8 are dropped.
- R2: `led_out` keeps its value on every cycle without an LED-window write. A read from the LED window returns 0 on `io_rdata` one cycle later.
- R3: `uart_wr_stb` (on a write) or `uart_rd_stb` (on a read) is high in the same cycle only for address 0x0080 or 0x0081, with `uart_reg_sel` equal to address bit 0 (0 = data, 1 = control). Addresses 0x0082..0x00BF raise neither strobe.
- R4: The cycle after a UART read strobe, `io_rdata` equals the `uart_rd_data` seen with the request. The cycle after any other cycle, `io_rdata` is 0.
- R5: In 0x00C0..0x00EF, address bits 5..4 select the LCD line: 00 register select (`lcd_rs`), 01 read/write (`lcd_rw`), 10 enable (`lcd_en`). A write sets the selected line to `io_wdata[0]` at the next edge.
- R6: A write to 0x00F0..0x00FF loads `lcd_nibble` with `io_wdata[7:4]` at the next edge.
- R7: An LCD line or the nibble changes only on a write to its own window. The enable line in particular never changes by itself.
- R8: A write to 0x8000..0xBFFF raises `pmem_wr_stb` in the same cycle, with `pmem_offset` equal to address bits 13..0.
- R9: A write to 0xC000..0xFFFF raises `vram_wr_stb` in the same cycle, with `vram_offset` equal to address bits 12..0.
- R10: A read raises no write strobe and changes no held register. Addresses 0x0040..0x007F and 0x0100..0x7FFF select no peripheral.
- R11: A synchronous reset clears `led_out`, the three LCD lines, `lcd_nibble` and `io_rdata` to 0.
- R12: `per_wdata` always equals `io_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | Bus address |
| io_wdata | input | 16 | Bus write data |
| io_wr | input | 1 | Write request |
| io_rd | input | 1 | Read request |
| io_rdata | output | 16 | Registered read data |
| led_out | output | 8 | LED levels, 1 = lit |
| uart_wr_stb | output | 1 | UART register write strobe |
| uart_rd_stb | output | 1 | UART register read strobe |
| uart_reg_sel | output | 1 | UART register select, 0 data, 1 control |
| uart_rd_data | input | 16 | UART read data, valid with the read strobe |
| lcd_rs | output | 1 | LCD register select line |
| lcd_rw | output | 1 | LCD read/write line |
| lcd_en | output | 1 | LCD enable line |
| lcd_nibble | output | 4 | LCD 4-bit data lines |
| pmem_wr_stb | output | 1 | Program memory write strobe |
| pmem_offset | output | 14 | Program memory word offset |
| vram_wr_stb | output | 1 | Video RAM write strobe |
| vram_offset | output | 13 | Video RAM byte offset |
| per_wdata | output | 16 | Write data forwarded to peripherals |

## Verification
Every one of the 65,536 addresses is written once, with data that changes along with the address. This shows that each prefix boundary, including the unused gap 0x0040..0x007F and the UART offsets next to 0x0080/0x0081, goes to the correct target, and that the LCD line selection uses the correct sub-field. All addresses are then read, with UART read data that also depends on the address. This separates the registered UART response from the zero response and confirms that reads leave the LED and LCD state unchanged. A reset issued while the registers hold nonzero values shows that the clear is synchronous and complete.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

  localparam int IO_AW = 16;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_LED,
    TGT_UART,
    TGT_LCD,
    TGT_PMEM,
    TGT_VRAM
  } io_target_e;

  // LCD line index carried in address bits 5..4
  typedef enum logic [1:0] {
    LCDL_RS  = 2'd0,
    LCDL_RW  = 2'd1,
    LCDL_EN  = 2'd2,
    LCDL_DAT = 2'd3
  } lcd_line_e;

  // Prefix match of variable length: 2 bits for the memories, 10 for the rest.
  function automatic io_target_e classify(input logic [IO_AW-1:0] a);
    if (a[15:14] == 2'b10) return TGT_PMEM;
    if (a[15:14] == 2'b11) return TGT_VRAM;
    if (a[15:8] != 8'h00)  return TGT_NONE;
    case (a[7:6])
      2'b00:   return TGT_LED;
      2'b10:   return TGT_UART;
      2'b11:   return TGT_LCD;
      default: return TGT_NONE;
    endcase
  endfunction

  // Only the first two offsets of the UART window are real registers.
  function automatic logic uart_slot_ok(input logic [IO_AW-1:0] a);
    return a[5:1] == 5'd0;
  endfunction

endpackage

// File: rtl/iobus_decode.sv
module iobus_decode
  import iobus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] addr,
  input  logic             wr,
  input  logic             rd,
  output logic             led_we,
  output logic [3:0]       lcd_we,
  output logic             uart_wr,
  output logic             uart_rd,
  output logic             pmem_we,
  output logic             vram_we
);

  io_target_e tgt;
  logic       uart_hit;

  assign tgt      = classify(addr);
  assign uart_hit = (tgt == TGT_UART) && uart_slot_ok(addr);

  assign led_we  = wr && (tgt == TGT_LED);
  assign uart_wr = wr && uart_hit;
  assign uart_rd = rd && uart_hit;
  assign pmem_we = wr && (tgt == TGT_PMEM);
  assign vram_we = wr && (tgt == TGT_VRAM);

  for (genvar g = 0; g < 4; g++) begin : g_lcd_sel
    assign lcd_we[g] = wr && (tgt == TGT_LCD) && (addr[5:4] == 2'(g));
  end

  // R10: a read never produces a write strobe
  assert_rd_no_wstb_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |-> !(led_we || (|lcd_we) || uart_wr || pmem_we || vram_we));

  // R3: UART strobes only on the two register offsets
  assert_uart_offsets_R3: assert property (@(posedge clk) disable iff (rst)
    (uart_wr || uart_rd) |-> (addr[15:1] == 15'h0040));

endmodule

// File: rtl/iobus_regs.sv
module iobus_regs #(
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             led_we,
  input  logic [3:0]       lcd_we,
  input  logic [7:0]       wd,
  output logic [LED_W-1:0] led,
  output logic [2:0]       lcd_line,
  output logic [3:0]       nibble
);

  localparam int LINES = 3;

  always_ff @(posedge clk) begin
    if (rst)         led <= '0;
    else if (led_we) led <= wd[LED_W-1:0];
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)            lcd_line[g] <= 1'b0;
      else if (lcd_we[g]) lcd_line[g] <= wd[0];
    end

    // R5: selected line follows write-data bit 0
    assert_line_load_R5: assert property (@(posedge clk) disable iff (rst)
      lcd_we[g] |=> (lcd_line[g] == $past(wd[0])));

    // R7: line holds without a write to its own window
    assert_line_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !lcd_we[g] |=> $stable(lcd_line[g]));
  end

  always_ff @(posedge clk) begin
    if (rst)            nibble <= '0;
    else if (lcd_we[3]) nibble <= wd[7:4];
  end

  // R1: LED register takes the low data byte
  assert_led_load_R1: assert property (@(posedge clk) disable iff (rst)
    led_we |=> (led == $past(wd[LED_W-1:0])));

  // R2: LED register holds otherwise
  assert_led_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !led_we |=> $stable(led));

  // R6: nibble comes from data bits 7..4
  assert_nibble_load_R6: assert property (@(posedge clk) disable iff (rst)
    lcd_we[3] |=> (nibble == $past(wd[7:4])));

endmodule

// File: rtl/iobus_rdpath.sv
module iobus_rdpath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uart_rd,
  input  logic [DATA_W-1:0] uart_data,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (uart_rd) rdata <= uart_data;
    else              rdata <= '0;
  end

  // R4: registered UART response one cycle after the strobe
  assert_uart_resp_R4: assert property (@(posedge clk) disable iff (rst)
    uart_rd |=> (rdata == $past(uart_data)));

  // R4: every other cycle answers zero
  assert_zero_resp_R4: assert property (@(posedge clk) disable iff (rst)
    !uart_rd |=> (rdata == '0));

endmodule

// File: rtl/iobus_router.sv
module iobus_router #(
  parameter int DATA_W  = 16,
  parameter int LED_W   = 8,
  parameter int PMEM_AW = 14,
  parameter int VRAM_AW = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        io_addr,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic               io_wr,
  input  logic               io_rd,
  output logic [DATA_W-1:0]  io_rdata,
  output logic [LED_W-1:0]   led_out,
  output logic               uart_wr_stb,
  output logic               uart_rd_stb,
  output logic               uart_reg_sel,
  input  logic [DATA_W-1:0]  uart_rd_data,
  output logic               lcd_rs,
  output logic               lcd_rw,
  output logic               lcd_en,
  output logic [3:0]         lcd_nibble,
  output logic               pmem_wr_stb,
  output logic [PMEM_AW-1:0] pmem_offset,
  output logic               vram_wr_stb,
  output logic [VRAM_AW-1:0] vram_offset,
  output logic [DATA_W-1:0]  per_wdata
);

  import iobus_pkg::*;

  logic       led_we;
  logic [3:0] lcd_we;
  logic [2:0] lcd_line;

  iobus_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .addr    (io_addr),
    .wr      (io_wr),
    .rd      (io_rd),
    .led_we  (led_we),
    .lcd_we  (lcd_we),
    .uart_wr (uart_wr_stb),
    .uart_rd (uart_rd_stb),
    .pmem_we (pmem_wr_stb),
    .vram_we (vram_wr_stb)
  );

  iobus_regs #(.LED_W(LED_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .led_we   (led_we),
    .lcd_we   (lcd_we),
    .wd       (io_wdata[7:0]),
    .led      (led_out),
    .lcd_line (lcd_line),
    .nibble   (lcd_nibble)
  );

  iobus_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .uart_rd   (uart_rd_stb),
    .uart_data (uart_rd_data),
    .rdata     (io_rdata)
  );

  assign lcd_rs       = lcd_line[LCDL_RS];
  assign lcd_rw       = lcd_line[LCDL_RW];
  assign lcd_en       = lcd_line[LCDL_EN];
  assign uart_reg_sel = io_addr[0];
  assign pmem_offset  = io_addr[PMEM_AW-1:0];
  assign vram_offset  = io_addr[VRAM_AW-1:0];
  assign per_wdata    = io_wdata;

  // R10: one target at most per access
  assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({led_we, |lcd_we, uart_wr_stb, pmem_wr_stb, vram_wr_stb}));

  // R8: program-memory strobe only for prefix 10 writes
  assert_pmem_prefix_R8: assert property (@(posedge clk) disable iff (rst)
    pmem_wr_stb |-> (io_wr && io_addr[15:14] == 2'b10));

  // R9: video strobe only for prefix 11 writes
  assert_vram_prefix_R9: assert property (@(posedge clk) disable iff (rst)
    vram_wr_stb |-> (io_wr && io_addr[15:14] == 2'b11));

endmodule

// File: tb/sim_iobus_router.sv
module sim_iobus_router;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, io_wr, io_rd;
  logic [15:0] io_addr, io_wdata, io_rdata, uart_rd_data, per_wdata;
  logic [7:0]  led_out;
  logic        uart_wr_stb, uart_rd_stb, uart_reg_sel;
  logic        lcd_rs, lcd_rw, lcd_en;
  logic [3:0]  lcd_nibble;
  logic        pmem_wr_stb, vram_wr_stb;
  logic [13:0] pmem_offset;
  logic [12:0] vram_offset;

  iobus_router u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_led;
  logic        m_rs, m_rw, m_en;
  logic [3:0]  m_nib;
  logic [15:0] m_rdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h addr=%h", tag, act, exp, io_addr);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check_held();
    chk("R1/R2 led", 32'(led_out), 32'(m_led));
    chk("R5/R7 rs", 32'(lcd_rs), 32'(m_rs));
    chk("R5/R7 rw", 32'(lcd_rw), 32'(m_rw));
    chk("R5/R7 en", 32'(lcd_en), 32'(m_en));
    chk("R6/R7 nibble", 32'(lcd_nibble), 32'(m_nib));
    chk("R4 rdata", 32'(io_rdata), 32'(m_rdata));
  endtask

  function automatic bit is_uart(input int a);
    return (a == 'h80) || (a == 'h81);
  endfunction

  initial begin
    rst = 1'b1; io_wr = 1'b0; io_rd = 1'b0;
    io_addr = '0; io_wdata = '0; uart_rd_data = '0;
    m_led = '0; m_rs = 0; m_rw = 0; m_en = 0; m_nib = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 led", 32'(led_out), 0);
    chk("R11 lcd", 32'({lcd_rs, lcd_rw, lcd_en, lcd_nibble}), 0);
    chk("R11 rdata", 32'(io_rdata), 0);
    rst = 1'b0;

    // write sweep over the full address space
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      check_held();
      io_addr  = 16'(a);
      io_wdata = 16'(a * 40503) ^ 16'h5A5A;
      io_wr    = 1'b1;
      io_rd    = 1'b0;
      #1;
      chk("R3 uart_wr", 32'(uart_wr_stb), 32'(is_uart(a)));
      chk("R10 uart_rd on write", 32'(uart_rd_stb), 0);
      if (is_uart(a)) chk("R3 reg_sel", 32'(uart_reg_sel), 32'(a % 2));
      chk("R8 pmem_we", 32'(pmem_wr_stb), 32'(a >= 'h8000 && a < 'hC000));
      if (a >= 'h8000 && a < 'hC000) chk("R8 pmem_offset", 32'(pmem_offset), 32'(a - 'h8000));
      chk("R9 vram_we", 32'(vram_wr_stb), 32'(a >= 'hC000));
      if (a >= 'hC000) chk("R9 vram_offset", 32'(vram_offset), 32'(a % 8192));
      chk("R12 per_wdata", 32'(per_wdata), 32'(io_wdata));
      if (a < 'h40) m_led = io_wdata[7:0];
      if (a >= 'hC0 && a < 'h100) begin
        case ((a - 'hC0) / 16)
          0: m_rs = io_wdata[0];
          1: m_rw = io_wdata[0];
          2: m_en = io_wdata[0];
          default: m_nib = 4'((io_wdata / 16) % 16);
        endcase
      end
      m_rdata = '0;
    end

    // read sweep: nothing held may change, only UART answers
    for (int a = 0; a < 65536; a++) begin
      @(negedge clk);
      check_held();
      io_wr        = 1'b0;
      io_rd        = 1'b1;
      io_addr      = 16'(a);
      uart_rd_data = ~16'(a) ^ 16'h1234;
      #1;
      chk("R3 uart_rd", 32'(uart_rd_stb), 32'(is_uart(a)));
      if (is_uart(a)) chk("R3 reg_sel rd", 32'(uart_reg_sel), 32'(a % 2));
      chk("R10 no wstb on read", 32'({uart_wr_stb, pmem_wr_stb, vram_wr_stb}), 0);
      m_rdata = is_uart(a) ? uart_rd_data : 16'h0;
    end
    @(negedge clk);
    check_held();
    io_rd = 1'b0;

    // LED known nonzero, then reset
    io_addr = 16'h0012; io_wdata = 16'hFF3C; io_wr = 1'b1;
    @(negedge clk);
    chk("R1 led upper bits dropped", 32'(led_out), 32'h3C);
    io_wr = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R11 led", 32'(led_out), 0);
    chk("R11 lcd", 32'({lcd_rs, lcd_rw, lcd_en, lcd_nibble}), 0);
    chk("R11 rdata", 32'(io_rdata), 0);
    rst = 1'b0;

    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

endmodule